// File: doc/BRIEF.md
# Serial Clock-Mask Loader with Secondary Reset Hold

This block reads a 16-bit clock-enable mask from an external parallel-in/serial-out shift register each time the primary reset is released. It runs that register with two outputs. One is a shift clock, made by dividing the core clock. The other is a select line that chooses between a parallel load and a shift. The mask arrives one bit at a time on a serial input. Until all 16 bits are in, the block holds the secondary-side reset asserted.

The captured mask is decoded into clock enables for nine device clocks and one feedback clock. A mask bit of 0 means enabled. Each of the first four devices takes two mask bits, one per presence pin. The next five devices each take one bit, the feedback clock takes one bit, and the top two bits are unused.

After startup, software can replace the mask through a write port. A write that arrives before the capture has completed is held and applied afterwards, so the serial value never overwrites it.

Top module: `clkmask_loader`

## Requirements
- R1: Once `prim_rst_n` is seen high, the block produces exactly 17 rising edges on `sh_clk`: one load pulse followed by 16 shift pulses. It then stops until the primary reset is asserted and released again.
- R2: `sec_rst_n` is 0 while `prim_rst_n` is low and throughout the capture. It goes to 1 in the same cycle that `done` is 1, never earlier.
- R3: `sh_ld` is 1 (load) during the first shift-clock pulse and 0 (shift) during the 16 that follow. It does not change while `sh_clk` is high.
- R4: The `sh_clk` period is `DIV` core-clock cycles (default 4). The clock is high for the second half of each period.
- R5: `ser_in` is sampled in the core cycle in which `sh_clk` rises, but only on shift pulses. The first bit sampled becomes mask bit 15 and the last becomes mask bit 0.
- R6: A mask bit of 0 enables its clock and a 1 disables it. If `ser_in` is held at 0, every enable is 1.
- R7: Mask bits {1,0}, {3,2}, {5,4} and {7,6} belong to devices 0 to 3. A device's enable is 0 only when both bits of its pair are 1.
- R8: Mask bits 8 to 12 drive `dev_clk_en[4]` to `dev_clk_en[8]` inverted. Bit 13 drives `fb_clk_en` inverted. Bits 14 and 15 have no effect on any output.
- R9: When `wr_en` is 1 after the capture has completed, `wr_data` replaces the mask. The enables show the new value one cycle after the write edge.
- R10: A write made before the capture completes is held back. The enables first show the serial value for one cycle, and the written value takes effect the cycle after that.
- R11: While `rst` is 1, the mask is cleared to all zeros, all enables are 1 one cycle later, `sec_rst_n` is 0 and `sh_clk` is 0.
- R12: `done` is 1 for exactly one cycle per completed capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous core reset, active high |
| prim_rst_n | input | 1 | Primary reset, active low; its release starts a capture |
| ser_in | input | 1 | Serial mask data from the external shift register |
| wr_en | input | 1 | Software write strobe for the mask |
| wr_data | input | 16 | Mask value to write |
| sh_clk | output | 1 | Shift clock to the external register |
| sh_ld | output | 1 | 1 = parallel load, 0 = shift |
| sec_rst_n | output | 1 | Secondary reset, active low |
| done | output | 1 | One-cycle pulse when a capture completes |
| dev_clk_en | output | 9 | Per-device clock enables, 1 = running |
| fb_clk_en | output | 1 | Feedback clock enable, 1 = running |

## Verification
The bench models the external shift register and checks several serial patterns against the expected decode. It targets these failure cases:
- A design that samples the bit presented during the load pulse, or takes bits in the wrong order, decodes the mask shifted by one bit or reversed.
- A design that reads the presence pairs with OR instead of AND turns a device off when only one of its pins is high.
- A design that decodes the reserved bits gets the all-ones-in-bits-14-and-15 pattern wrong.
- A design that applies a write immediately during capture loses that write, because the serial result lands on top of it.
- A design that releases the secondary reset early shows it high in the middle of the capture.

// File: rtl/clkmask_pkg.sv
package clkmask_pkg;
  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_LOAD  = 2'd1,
    LS_SHIFT = 2'd2,
    LS_RUN   = 2'd3
  } ld_state_t;
endpackage

// File: rtl/clkmask_tick.sv
module clkmask_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic rise,
  output logic fall
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] RISEP = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign rise = active && (cnt == RISEP);
  assign fall = active && (cnt == LAST);
endmodule

// File: rtl/clkmask_seq.sv
module clkmask_seq
  import clkmask_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prim_rst_n,
  input  logic              ser_in,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_data,
  input  logic              rise,
  input  logic              fall,
  output logic              active,
  output logic              sh_clk,
  output logic              sh_ld,
  output logic              sec_rst_n,
  output logic              done,
  output logic [MASK_W-1:0] mask
);
  localparam int BW = $clog2(MASK_W + 1);
  localparam logic [BW-1:0] NBITS = BW'(MASK_W);

  ld_state_t         state;
  logic [BW-1:0]     bitcnt;
  logic [MASK_W-1:0] shreg;
  logic              pend;
  logic [MASK_W-1:0] pend_data;

  assign active = (state == LS_LOAD) || (state == LS_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LS_IDLE;
      sh_clk    <= 1'b0;
      sh_ld     <= 1'b1;
      sec_rst_n <= 1'b0;
      done      <= 1'b0;
      bitcnt    <= '0;
      shreg     <= '0;
      mask      <= '0;
      pend      <= 1'b0;
      pend_data <= '0;
    end else begin
      done <= 1'b0;
      if (!prim_rst_n) begin
        state     <= LS_IDLE;
        sh_clk    <= 1'b0;
        sh_ld     <= 1'b1;
        sec_rst_n <= 1'b0;
        bitcnt    <= '0;
      end else begin
        case (state)
          LS_IDLE: begin
            state <= LS_LOAD;
            sh_ld <= 1'b1;
          end
          LS_LOAD: begin
            if (rise) sh_clk <= 1'b1;
            if (fall) begin
              sh_clk <= 1'b0;
              sh_ld  <= 1'b0;
              state  <= LS_SHIFT;
            end
          end
          LS_SHIFT: begin
            if (rise) begin
              sh_clk <= 1'b1;
              shreg  <= {shreg[MASK_W-2:0], ser_in};
              bitcnt <= bitcnt + 1'b1;
            end
            if (fall) begin
              sh_clk <= 1'b0;
              if (bitcnt == NBITS) begin
                state     <= LS_RUN;
                mask      <= shreg;
                sec_rst_n <= 1'b1;
                done      <= 1'b1;
                sh_ld     <= 1'b1;
              end
            end
          end
          default: begin
            if (pend) begin
              mask <= pend_data;
              pend <= 1'b0;
            end
          end
        endcase
      end
      if (wr_en) begin
        if (state == LS_RUN && prim_rst_n) begin
          mask <= wr_data;
          pend <= 1'b0;
        end else begin
          pend      <= 1'b1;
          pend_data <= wr_data;
        end
      end
    end
  end

  assert_bitcnt_limit_R1: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= NBITS);
  assert_secrst_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_rst_n) |-> done);
  assert_prim_holds_sec_R2: assert property (@(posedge clk) disable iff (rst)
    !prim_rst_n |=> !sec_rst_n);
  assert_sel_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (sh_clk && $past(sh_clk)) |-> $stable(sh_ld));
  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/clkmask_decode.sv
module clkmask_decode #(
  parameter int MASK_W = 16,
  parameter int N_PAIR = 4,
  parameter int N_SGL  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MASK_W-1:0]        mask,
  output logic [N_PAIR+N_SGL-1:0]  dev_en,
  output logic                     fb_en
);
  localparam int N_DEV  = N_PAIR + N_SGL;
  localparam int SGL_LO = 2 * N_PAIR;
  localparam int FB_BIT = SGL_LO + N_SGL;

  logic [N_DEV-1:0] nx_dev;

  for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
    assign nx_dev[i] = ~(mask[2*i] & mask[2*i+1]);
  end
  for (genvar k = 0; k < N_SGL; k++) begin : g_sgl
    assign nx_dev[N_PAIR+k] = ~mask[SGL_LO+k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_en <= '1;
      fb_en  <= 1'b1;
    end else begin
      dev_en <= nx_dev;
      fb_en  <= ~mask[FB_BIT];
    end
  end

  assert_zero_mask_all_on_R6: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> ((&dev_en) && fb_en));
  assert_full_mask_all_off_R7: assert property (@(posedge clk) disable iff (rst)
    (&mask[FB_BIT:0]) |=> ((dev_en == '0) && !fb_en));
endmodule

// File: rtl/clkmask_loader.sv
module clkmask_loader #(
  parameter int MASK_W = 16,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prim_rst_n,
  input  logic              ser_in,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_data,
  output logic              sh_clk,
  output logic              sh_ld,
  output logic              sec_rst_n,
  output logic              done,
  output logic [8:0]        dev_clk_en,
  output logic              fb_clk_en
);
  localparam int N_PAIR = 4;
  localparam int N_SGL  = 5;

  logic active, rise, fall;
  logic [MASK_W-1:0] mask;

  clkmask_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .active(active), .rise(rise), .fall(fall)
  );

  clkmask_seq #(.MASK_W(MASK_W)) u_seq (
    .clk(clk), .rst(rst), .prim_rst_n(prim_rst_n), .ser_in(ser_in),
    .wr_en(wr_en), .wr_data(wr_data), .rise(rise), .fall(fall),
    .active(active), .sh_clk(sh_clk), .sh_ld(sh_ld),
    .sec_rst_n(sec_rst_n), .done(done), .mask(mask)
  );

  clkmask_decode #(.MASK_W(MASK_W), .N_PAIR(N_PAIR), .N_SGL(N_SGL)) u_dec (
    .clk(clk), .rst(rst), .mask(mask), .dev_en(dev_clk_en), .fb_en(fb_clk_en)
  );

  assert_clk_idle_in_reset_R11: assert property (@(posedge clk)
    rst |=> (!sh_clk && !sec_rst_n));
endmodule

// File: tb/clkmask_loader_tb_top.sv
`timescale 1ns/1ps
module clkmask_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prim_rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic sh_clk, sh_ld, sec_rst_n, done, fb_clk_en;
  logic [8:0] dev_clk_en;

  always #2 clk = ~clk;

  clkmask_loader dut_i (
    .clk(clk), .rst(rst), .prim_rst_n(prim_rst_n), .ser_in(ser_in),
    .wr_en(wr_en), .wr_data(wr_data), .sh_clk(sh_clk), .sh_ld(sh_ld),
    .sec_rst_n(sec_rst_n), .done(done), .dev_clk_en(dev_clk_en),
    .fb_clk_en(fb_clk_en)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int ncap = 0;
  logic [9:0] sb_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_en(input logic [15:0] m);
    logic [9:0] e;
    for (int i = 0; i < 4; i++) e[i] = !(m[2*i] && m[2*i+1]);
    for (int k = 0; k < 5; k++) e[4+k] = !m[8+k];
    e[9] = !m[13];
    return e;
  endfunction

  // external shift-register model
  logic [15:0] pat = '0;
  int idx = 15;
  int ld_cnt = 0, sh_cnt = 0, order_bad = 0, per_bad = 0;
  longint prev_t = -1;
  always @(posedge sh_clk) begin
    if (sh_ld) begin
      ld_cnt++;
      if (sh_cnt != 0) order_bad++;
      idx = 15;
    end else begin
      sh_cnt++;
      idx--;
    end
    if (prev_t >= 0 && ($time - prev_t) != 16) per_bad++;
    prev_t = $time;
    #1 ser_in = (idx >= 0) ? pat[idx] : 1'b0;
  end

  // monitor: scoreboard compare on each completed capture
  initial forever begin
    @(posedge clk); #1;
    if (done) begin
      chk(sec_rst_n === 1'b1, "R2 release with done", 32'(sec_rst_n), 1);
      chk(ld_cnt == 1 && sh_cnt == 16, "R1 pulse count", 32'(ld_cnt*100 + sh_cnt), 116);
      chk(order_bad == 0, "R3 load before shifts", 32'(order_bad), 0);
      chk(per_bad == 0, "R4 shift clock period", 32'(per_bad), 0);
      @(posedge clk); #1;
      chk(done === 1'b0, "R12 done single cycle", 32'(done), 0);
      if (sb_q.size() == 0) chk(1'b0, "R5 unexpected capture", 1, 0);
      else begin
        logic [9:0] e;
        e = sb_q.pop_front();
        chk({fb_clk_en, dev_clk_en} === e, "R5/R7/R8 captured decode",
            32'({fb_clk_en, dev_clk_en}), 32'(e));
      end
      ncap++;
    end
  end

  task automatic capture(input logic [15:0] p, input bit mid_wr, input logic [15:0] wv);
    int c0;
    prim_rst_n = 1'b0;
    repeat (3) @(posedge clk); #1;
    pat = p; ser_in = 1'b0;
    ld_cnt = 0; sh_cnt = 0; order_bad = 0; per_bad = 0; prev_t = -1;
    sb_q.push_back(exp_en(p));
    c0 = ncap;
    prim_rst_n = 1'b1;
    repeat (20) @(posedge clk); #1;
    chk(sec_rst_n === 1'b0, "R2 held during capture", 32'(sec_rst_n), 0);
    if (mid_wr) begin
      wr_en = 1'b1; wr_data = wv;
      @(posedge clk); #1;
      wr_en = 1'b0;
    end
    while (ncap == c0) @(posedge clk);
    @(posedge clk); #1;
    if (mid_wr)
      chk({fb_clk_en, dev_clk_en} === exp_en(wv), "R10 deferred write",
          32'({fb_clk_en, dev_clk_en}), 32'(exp_en(wv)));
  endtask

  task automatic sw_write(input logic [15:0] v);
    logic [9:0] old;
    old = {fb_clk_en, dev_clk_en};
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk({fb_clk_en, dev_clk_en} === old, "R9 one-cycle latency", 32'({fb_clk_en, dev_clk_en}), 32'(old));
    @(posedge clk); #1;
    chk({fb_clk_en, dev_clk_en} === exp_en(v), "R9 write applied",
        32'({fb_clk_en, dev_clk_en}), 32'(exp_en(v)));
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    chk(sec_rst_n === 1'b0, "R11 reset sec", 32'(sec_rst_n), 0);
    chk(sh_clk === 1'b0, "R11 reset shclk", 32'(sh_clk), 0);
    chk({fb_clk_en, dev_clk_en} === 10'h3FF, "R11 reset enables", 32'({fb_clk_en, dev_clk_en}), 32'h3FF);
    rst = 1'b0;
    repeat (4) @(posedge clk); #1;
    chk(sec_rst_n === 1'b0, "R2 low while primary low", 32'(sec_rst_n), 0);

    capture(16'h0000, 0, '0);                     // R6 serial input low
    chk({fb_clk_en, dev_clk_en} === 10'h3FF, "R6 all enabled", 32'({fb_clk_en, dev_clk_en}), 32'h3FF);
    capture(16'hFFFF, 0, '0);                     // R7 R8 all off
    chk({fb_clk_en, dev_clk_en} === 10'h000, "R7 all disabled", 32'({fb_clk_en, dev_clk_en}), 0);
    capture(16'h2A96, 0, '0);                     // R7 mixed pairs
    capture(16'h1C0E, 0, '0);                     // R5 bit order
    capture(16'hC000, 0, '0);                     // R8 ignored bits
    chk({fb_clk_en, dev_clk_en} === 10'h3FF, "R8 reserved ignored", 32'({fb_clk_en, dev_clk_en}), 32'h3FF);
    capture(16'h0001, 0, '0);                     // R7 single pin low keeps enable
    chk(dev_clk_en[0] === 1'b1, "R7 one pin of pair", 32'(dev_clk_en[0]), 1);

    sw_write(16'h3FFF);
    sw_write(16'h0A50);
    capture(16'h00FF, 1, 16'h2100);               // R10

    repeat (30) @(posedge clk); #1;
    chk(sh_clk === 1'b0 && ld_cnt == 1, "R1 no further pulses", 32'(ld_cnt), 1);

    rst = 1'b1; prim_rst_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk({fb_clk_en, dev_clk_en} === 10'h3FF, "R11 mask cleared", 32'({fb_clk_en, dev_clk_en}), 32'h3FF);
    chk(sec_rst_n === 1'b0, "R11 sec asserted", 32'(sec_rst_n), 0);
    rst = 1'b0;
    repeat (3) @(posedge clk); #1;

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule